// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block maps CPU physical addresses onto the DRAM chip selects. Each chip select has a window that software sets up through a small 32-bit register port. A window has an enable bit, a base address and a size. For every request address, the block reports three things one cycle later: whether any window matched, which chip-select index won, and the attribute byte that device-side address windows must carry for that chip select.

The block also presents a summary of the windows that device DMA engines can reach. These are the enabled windows whose base lies below 4 GB. They are packed in ascending chip-select order, and a count goes with them, so that drivers of DMA-capable devices can program their own windows. The attribute gives each chip select the low nibble 0xF with that chip select's bit cleared. Bit 4 of the attribute is set while the coherency input is high.

A build-time parameter selects a compact two-window variant. In this variant each chip select has one packed map register: an enable bit, a base at 8 MB granularity and a power-of-two size code. The attribute byte is always zero in this variant.

Top module: `dram_cs_decoder`

## Requirements
- R1: In the standard layout, window i has its base register at byte offset 8·i and its size register at 8·i+4, for i = 0..3. A read returns the stored 32-bit value on reg_rdata in the cycle after reg_rd_en. Unaligned or unmapped offsets read as zero, and writes to them are dropped.
- R2: Reset clears every register. After reset, no request hits and the DMA count is zero.
- R3: Size register: bit 0 is enable and bits 4:2 hold a chip-select number, which is stored only. Bits 31:24 hold bits 31:24 of (size − 1), so the window covers base through base + {bits 31:24, 24'hFFFFFF} inclusive. The granularity is 16 MB.
- R4: Base register: bits 31:24 become address bits 31:24 and bits 3:0 become address bits 35:32. The other address bits are zero.
- R5: When several enabled windows contain the address, the lowest window index is reported.
- R6: On a hit in the standard layout, res_attr is {3'b000, coh_en, 4'hF with bit i cleared}, where i is the winning window and coh_en is sampled with the request.
- R7: A window whose enable bit is 0 never hits, whatever its base and size. Once its enable bit is set it hits.
- R8: The DMA summary lists, in ascending window order, every enabled window whose base bits 35:32 are zero. For each, entry k holds the chip-select index, the attribute, the low 32 base bits and size − 1. dma_count gives the number of entries, and unused entries are zero. The summary follows a register write by two cycles.
- R9: Variant (PACKED_MAP=1, two windows): the map register for window i sits at offset 16·i, and other offsets read as zero. Bit 0 is enable, bits 31:23 are address bits 31:23, and bits 19:16 are a code c with size = 1 MB << (c − 4). The attribute is always 0.
- R10: A code c below 4 in the variant makes the window behave as disabled.
- R11: res_valid is high exactly one cycle after req_valid. On a miss, res_hit, res_cs and res_attr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (8) | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd_en |
| coh_en | input | 1 | Hardware I/O coherency active; sets attribute bit 4 |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 36 | Physical request address |
| res_valid | output | 1 | Result strobe, one cycle after req_valid |
| res_hit | output | 1 | Some window matched |
| res_cs | output | CS_W (2) | Winning window index |
| res_attr | output | 8 | Attribute byte of the winning window |
| dma_count | output | CNT_W (3) | Number of DMA-reachable windows |
| dma_cs | output | NWIN·CS_W (8) | Packed chip-select indices |
| dma_attr | output | NWIN·8 (32) | Packed attribute bytes |
| dma_base | output | NWIN·32 (128) | Packed low 32 base bits |
| dma_szm1 | output | NWIN·32 (128) | Packed size minus one |

## Verification
The hardest situation to reach from the ports is a window that the DMA summary drops while the address decoder still uses it. The bench creates it by giving one window a non-zero high base nibble. It then checks two things: that this window still decodes addresses above 8 GB, and that the remaining windows close up in the summary. A second hard case is an overlap that lowest-index priority has to resolve. The bench moves a higher window onto an existing one and then disables the lower window, to show both the priority and the hand-over. The bench also drives the coherency input and a variant instance with an out-of-range size code.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int PA_W = 36;

  typedef struct packed {
    logic            en;
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] szm1;
    logic [PA_W-1:0] last;
    logic [7:0]      attr;
  } win_t;
endpackage

// File: rtl/dcs_regfile.sv
module dcs_regfile #(
  parameter int NWIN       = 4,
  parameter bit PACKED_MAP = 1'b0,
  parameter int REG_AW     = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [REG_AW-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [NWIN-1:0][31:0]  reg_a,
  output logic [NWIN-1:0][31:0]  reg_b
);
  localparam int STRIDE_LG = PACKED_MAP ? 4 : 3;
  localparam int IW        = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [REG_AW-1:0] LOW_MASK = PACKED_MAP ? REG_AW'(15) : REG_AW'(3);

  logic [REG_AW-1:0] idx_full;
  logic [IW-1:0]     idx;
  logic              mapped;
  logic              sel_b;

  assign idx_full = addr >> STRIDE_LG;
  assign idx      = idx_full[IW-1:0];
  assign mapped   = ((addr & LOW_MASK) == '0) && (idx_full < REG_AW'(NWIN));
  assign sel_b    = !PACKED_MAP && addr[2];

  always_ff @(posedge clk) begin
    if (rst) reg_a <= '0;
    else if (wr_en && mapped && !sel_b) reg_a[idx] <= wdata;
  end

  generate
    if (PACKED_MAP) begin : g_single
      assign reg_b = '0;
    end else begin : g_pair
      always_ff @(posedge clk) begin
        if (rst) reg_b <= '0;
        else if (wr_en && mapped && sel_b) reg_b[idx] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= !mapped ? 32'h0 : (sel_b ? reg_b[idx] : reg_a[idx]);
  end
endmodule

// File: rtl/dcs_win_decode.sv
module dcs_win_decode
  import dcs_pkg::*;
#(
  parameter int IDX        = 0,
  parameter bit PACKED_MAP = 1'b0
) (
  input  logic [31:0] base_reg,
  input  logic [31:0] size_reg,
  input  logic        coh_en,
  output win_t        win
);
  generate
    if (!PACKED_MAP) begin : g_std
      logic unused_std;
      assign unused_std = ^{base_reg[23:4], size_reg[23:1]};
      always_comb begin
        win.en   = size_reg[0];
        win.base = {base_reg[3:0], base_reg[31:24], 24'h0};
        win.szm1 = {4'h0, size_reg[31:24], 24'hFF_FFFF};
        win.last = win.base + win.szm1;
        win.attr = {3'b000, coh_en, 4'hF & ~(4'(1) << IDX)};
      end
    end else begin : g_map
      logic [3:0] code;
      logic       unused_map;
      assign code       = base_reg[19:16];
      assign unused_map = ^{base_reg[22:20], base_reg[15:1], size_reg, coh_en};
      always_comb begin
        win.en   = base_reg[0] && (code >= 4'd4);
        win.base = {4'h0, base_reg[31:23], 23'h0};
        win.szm1 = (36'd1 << (6'(code) + 6'd16)) - 36'd1;
        win.last = win.base + win.szm1;
        win.attr = 8'h00;
      end
    end
  endgenerate
endmodule

// File: rtl/dcs_match.sv
module dcs_match
  import dcs_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int CS_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  win_t [NWIN-1:0]      wins,
  input  logic                 req_valid,
  input  logic [PA_W-1:0]      req_addr,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic [CS_W-1:0]      res_cs,
  output logic [7:0]           res_attr
);
  logic            hit_any;
  logic [CS_W-1:0] sel;
  logic [7:0]      sel_attr;
  logic [NWIN-1:0] en_vec;

  always_comb begin
    hit_any  = 1'b0;
    sel      = '0;
    sel_attr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      en_vec[i] = wins[i].en;
      if (wins[i].en && req_addr >= wins[i].base && req_addr <= wins[i].last) begin
        hit_any  = 1'b1;
        sel      = CS_W'(i);
        sel_attr = wins[i].attr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_cs    <= '0;
      res_attr  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_hit  <= hit_any;
        res_cs   <= sel;
        res_attr <= sel_attr;
      end
    end
  end

  // R11
  resp_lat_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_cs == '0 && res_attr == 8'h00));
  // R7
  en_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (($past(en_vec) & (NWIN'(1) << res_cs)) != '0));
  // R6
  attr_bit_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> !res_attr[res_cs]);
endmodule

// File: rtl/dcs_dma_pack.sv
module dcs_dma_pack
  import dcs_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int CS_W  = 2,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  win_t [NWIN-1:0]        wins,
  output logic [CNT_W-1:0]       dma_count,
  output logic [NWIN*CS_W-1:0]   dma_cs,
  output logic [NWIN*8-1:0]      dma_attr,
  output logic [NWIN*32-1:0]     dma_base,
  output logic [NWIN*32-1:0]     dma_szm1
);
  logic [CNT_W-1:0]     n;
  logic [NWIN*CS_W-1:0] cs_n;
  logic [NWIN*8-1:0]    attr_n;
  logic [NWIN*32-1:0]   base_n;
  logic [NWIN*32-1:0]   szm1_n;

  always_comb begin
    n      = '0;
    cs_n   = '0;
    attr_n = '0;
    base_n = '0;
    szm1_n = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (wins[i].en && wins[i].base[PA_W-1:32] == '0) begin
        cs_n[n*CS_W +: CS_W] = CS_W'(i);
        attr_n[n*8 +: 8]     = wins[i].attr;
        base_n[n*32 +: 32]   = wins[i].base[31:0];
        szm1_n[n*32 +: 32]   = wins[i].szm1[31:0];
        n = n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_count <= '0;
      dma_cs    <= '0;
      dma_attr  <= '0;
      dma_base  <= '0;
      dma_szm1  <= '0;
    end else begin
      dma_count <= n;
      dma_cs    <= cs_n;
      dma_attr  <= attr_n;
      dma_base  <= base_n;
      dma_szm1  <= szm1_n;
    end
  end

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    dma_count <= CNT_W'(NWIN));
endmodule

// File: rtl/dram_cs_decoder.sv
module dram_cs_decoder
  import dcs_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter bit PACKED_MAP = 1'b0,
  parameter int REG_AW     = 8,
  localparam int NWIN      = PACKED_MAP ? 2 : NUM_CS,
  localparam int CS_W      = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int CNT_W     = $clog2(NWIN + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  coh_en,
  input  logic                  req_valid,
  input  logic [35:0]           req_addr,
  output logic                  res_valid,
  output logic                  res_hit,
  output logic [CS_W-1:0]       res_cs,
  output logic [7:0]            res_attr,
  output logic [CNT_W-1:0]      dma_count,
  output logic [NWIN*CS_W-1:0]  dma_cs,
  output logic [NWIN*8-1:0]     dma_attr,
  output logic [NWIN*32-1:0]    dma_base,
  output logic [NWIN*32-1:0]    dma_szm1
);
  logic [NWIN-1:0][31:0] reg_a;
  logic [NWIN-1:0][31:0] reg_b;
  win_t [NWIN-1:0]       wins;

  dcs_regfile #(.NWIN(NWIN), .PACKED_MAP(PACKED_MAP), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .reg_a(reg_a), .reg_b(reg_b)
  );

  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_win
      dcs_win_decode #(.IDX(g), .PACKED_MAP(PACKED_MAP)) u_dec (
        .base_reg(reg_a[g]), .size_reg(reg_b[g]), .coh_en(coh_en), .win(wins[g])
      );
    end
  endgenerate

  dcs_match #(.NWIN(NWIN), .CS_W(CS_W)) u_match (
    .clk(clk), .rst(rst), .wins(wins), .req_valid(req_valid), .req_addr(req_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_cs(res_cs), .res_attr(res_attr)
  );

  dcs_dma_pack #(.NWIN(NWIN), .CS_W(CS_W), .CNT_W(CNT_W)) u_dma (
    .clk(clk), .rst(rst), .wins(wins), .dma_count(dma_count), .dma_cs(dma_cs),
    .dma_attr(dma_attr), .dma_base(dma_base), .dma_szm1(dma_szm1)
  );
endmodule

// File: tb/dram_cs_decoder_bench.sv
module dram_cs_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        wr_a = 0, wr_b = 0, rd_en = 0, coh_en = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_a = 0, req_b = 0;
  logic [35:0] req_addr = '0;

  logic [31:0]  rdata, v_rdata;
  logic         res_valid, res_hit, v_res_valid, v_res_hit;
  logic [1:0]   res_cs;
  logic [0:0]   v_res_cs;
  logic [7:0]   res_attr, v_res_attr;
  logic [2:0]   dma_count;
  logic [7:0]   dma_cs;
  logic [31:0]  dma_attr;
  logic [127:0] dma_base, dma_szm1;
  logic [1:0]   v_dma_count, v_dma_cs;
  logic [15:0]  v_dma_attr;
  logic [63:0]  v_dma_base, v_dma_szm1;

  dram_cs_decoder u_dram_cs_decoder (
    .clk(clk), .rst(rst), .reg_wr_en(wr_a), .reg_rd_en(rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .coh_en(coh_en), .req_valid(req_a),
    .req_addr(req_addr), .res_valid(res_valid), .res_hit(res_hit), .res_cs(res_cs),
    .res_attr(res_attr), .dma_count(dma_count), .dma_cs(dma_cs), .dma_attr(dma_attr),
    .dma_base(dma_base), .dma_szm1(dma_szm1)
  );

  dram_cs_decoder #(.PACKED_MAP(1'b1)) u_dram_cs_decoder_v (
    .clk(clk), .rst(rst), .reg_wr_en(wr_b), .reg_rd_en(rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(v_rdata), .coh_en(coh_en), .req_valid(req_b),
    .req_addr(req_addr), .res_valid(v_res_valid), .res_hit(v_res_hit), .res_cs(v_res_cs),
    .res_attr(v_res_attr), .dma_count(v_dma_count), .dma_cs(v_dma_cs),
    .dma_attr(v_dma_attr), .dma_base(v_dma_base), .dma_szm1(v_dma_szm1)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       hit;
    logic [1:0] cs;
    logic [7:0] attr;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit v, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d;
    if (v) wr_b = 1; else wr_a = 1;
    @(negedge clk);
    wr_a = 0; wr_b = 0;
  endtask

  task automatic rd(input bit v, input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(tag, v ? v_rdata : rdata, e);
  endtask

  // driver: main instance, expected result goes to the scoreboard
  task automatic drive(input logic [35:0] a, input logic h, input logic [1:0] cs,
                       input logic [7:0] at, input string tag);
    exp_t e;
    @(negedge clk);
    e.hit = h; e.cs = cs; e.attr = at; e.tag = tag;
    exp_q.push_back(e);
    req_addr = a; req_a = 1;
    @(negedge clk);
    req_a = 0;
  endtask

  // variant instance, checked directly
  task automatic vreq(input logic [35:0] a, input logic h, input logic cs, input string tag);
    @(negedge clk);
    req_addr = a; req_b = 1;
    @(negedge clk);
    req_b = 0;
    chk({tag, " valid"}, v_res_valid, 1'b1);
    chk(tag, {v_res_hit, v_res_cs, v_res_attr}, {h, cs, 8'h00});
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, {res_hit, res_cs, res_attr}, {e.hit, e.cs, e.attr});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 reset state
    rd(0, 8'h04, 32'h0, "R2 size reg after reset");
    chk("R2 dma count after reset", dma_count, 0);
    drive(36'h0_0000_0000, 0, 0, 8'h00, "R2 miss after reset");

    // program: cs0 0..256M, cs1 256M..512M, cs2 at 8G 16M, cs3 disabled at 1G
    wr(0, 8'h00, 32'h0000_0000); wr(0, 8'h04, 32'h0F00_0001);
    wr(0, 8'h08, 32'h1000_0000); wr(0, 8'h0C, 32'h0F00_0005);
    wr(0, 8'h10, 32'h0000_0002); wr(0, 8'h14, 32'h0000_0009);
    wr(0, 8'h18, 32'h4000_0000); wr(0, 8'h1C, 32'h0F00_000C);
    wr(0, 8'h40, 32'hDEAD_BEEF); wr(0, 8'h06, 32'hDEAD_BEEF);
    rd(0, 8'h1C, 32'h0F00_000C, "R1 size reg readback");
    rd(0, 8'h10, 32'h0000_0002, "R1 base reg readback");
    rd(0, 8'h40, 32'h0, "R1 unmapped offset");
    rd(0, 8'h04, 32'h0F00_0001, "R1 unaligned write dropped");

    drive(36'h0_0FFF_FFFF, 1, 0, 8'h0E, "R3 top of cs0");
    drive(36'h0_1000_0000, 1, 1, 8'h0D, "R3 bottom of cs1");
    drive(36'h0_1FFF_FFFF, 1, 1, 8'h0D, "R3 top of cs1");
    drive(36'h0_2000_0000, 0, 0, 8'h00, "R11 miss past cs1");
    drive(36'h2_0000_0000, 1, 2, 8'h0B, "R4 high base cs2");
    drive(36'h2_00FF_FFFF, 1, 2, 8'h0B, "R3 16MB granule cs2");
    drive(36'h2_0100_0000, 0, 0, 8'h00, "R3 past cs2");
    drive(36'h0_4000_0000, 0, 0, 8'h00, "R7 disabled cs3");

    chk("R8 count excludes high base", dma_count, 2);
    chk("R8 entry1 cs", dma_cs[3:2], 1);
    chk("R8 entry1 base", dma_base[63:32], 32'h1000_0000);
    chk("R8 entry1 size", dma_szm1[63:32], 32'h0FFF_FFFF);
    chk("R8 unused entry", dma_base[127:64], 64'h0);

    wr(0, 8'h1C, 32'h0F00_000D);
    settle();
    chk("R8 count after enable", dma_count, 3);
    chk("R8 entry2 cs", dma_cs[5:4], 3);
    chk("R8 entry2 base", dma_base[95:64], 32'h4000_0000);
    chk("R8 entry2 attr", dma_attr[23:16], 8'h07);
    drive(36'h0_4000_0000, 1, 3, 8'h07, "R7 cs3 enabled");

    wr(0, 8'h18, 32'h1000_0000);
    drive(36'h0_1800_0000, 1, 1, 8'h0D, "R5 lowest index wins");
    wr(0, 8'h0C, 32'h0F00_0004);
    drive(36'h0_1800_0000, 1, 3, 8'h07, "R5 cs3 after cs1 off");

    coh_en = 1;
    drive(36'h0_0000_0010, 1, 0, 8'h1E, "R6 coherency bit");
    settle();
    chk("R8 count after cs1 off", dma_count, 2);
    chk("R6 dma attr coherency", dma_attr[7:0], 8'h1E);
    chk("R8 entry1 now cs3", {dma_cs[3:2], dma_attr[15:8]}, {2'd3, 8'h17});

    // variant
    wr(1, 8'h10, 32'h0085_0001);
    wr(1, 8'h00, 32'h0003_0001);
    rd(1, 8'h10, 32'h0085_0001, "R9 map reg readback");
    rd(1, 8'h08, 32'h0, "R9 offset 8 unmapped");
    vreq(36'h0_0099_FFFF, 1, 1, "R9 inside 2MB window");
    vreq(36'h0_00A0_0000, 0, 0, "R9 past 2MB window");
    vreq(36'h0_0000_0000, 0, 0, "R10 code 3 disabled");
    chk("R10 variant dma count", v_dma_count, 1);
    wr(1, 8'h00, 32'h0004_0001);
    vreq(36'h0_000F_FFFF, 1, 0, "R9 code 4 is 1MB");
    vreq(36'h0_0010_0000, 0, 0, "R9 past 1MB");
    settle();
    chk("R9 variant dma", {v_dma_count, v_dma_cs, v_dma_attr}, {2'd2, 2'b10, 16'h0});

    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule